// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block is a small fully associative cache of page-table translations. Each lookup presents a virtual address and a read/write flag. Every stored entry compares its virtual page number with the request at the same moment. On a hit the physical address comes out in the same cycle. It is made of the stored physical page number followed by the untouched low offset bits. The buffer also reports the entry's reference and dirty flags as they stood before the access. The access then marks the entry as referenced and, for a write, as dirty.

When a lookup misses, the surrounding logic fetches the page-table entry and hands it back as a refill. A refill whose present bit is set is installed and the access can be retried. A refill whose present bit is clear is not installed; it turns into a one-cycle page-fault pulse. A refill for a page that is already held overwrites that entry. A new page goes into the lowest free entry. When no entry is free, a free-running pseudo-random sequence picks the entry to replace.

Top module: `page_xlat_buf`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and page_fault is low.
- R2: When lk_valid is high and a valid entry holds the page number lk_vaddr[31:12], hit is high and miss is low in the same cycle. paddr is then {stored physical page, lk_vaddr[11:0]}.
- R3: When lk_valid is high and no valid entry matches, miss is high and hit is low. When lk_valid is low, both are low.
- R4: On a hit, lk_ref and lk_dirty show the entry's stored flags. Both are low when there is no hit. After the clock edge that ends a hit, the entry's reference flag is set.
- R5: A hit with lk_write high also sets the entry's dirty flag at that edge. A read hit leaves the dirty flag unchanged.
- R6: A refill with fill_valid and fill_present high installs fill_vpn, fill_ppn, fill_ref and fill_dirty. The new entry is visible to lookups from the next cycle.
- R7: A refill with fill_present low raises page_fault for exactly the following cycle and leaves every entry unchanged. In all other cycles page_fault is low.
- R8: A refill whose page number is already held overwrites that same entry, so no page is ever held twice.
- R9: A refill for a new page, while any entry is invalid, goes into the lowest-numbered invalid entry.
- R10: When all entries are valid, a refill for a new page replaces the entry indexed by the low three bits of a 4-bit LFSR. The LFSR resets to 0001. Every cycle out of reset it becomes {q[2:0], q[3]^q[2]}. The value used is the one held before the installing edge.
- R11: When a lookup hits an entry in the same cycle as a refill overwrites that entry, the refill's contents and flags are what remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| hit | output | 1 | Lookup found a translation |
| miss | output | 1 | Lookup found no translation |
| paddr | output | 32 | Translated physical address |
| lk_ref | output | 1 | Stored reference flag of the hit entry |
| lk_dirty | output | 1 | Stored dirty flag of the hit entry |
| fill_valid | input | 1 | Refill strobe |
| fill_present | input | 1 | Present bit of the page-table entry |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| fill_ref | input | 1 | Reference flag to install |
| fill_dirty | input | 1 | Dirty flag to install |
| page_fault | output | 1 | Refill had its present bit clear |

## Verification
The hardest case to reach is random replacement. The victim depends on the LFSR phase at the exact installing edge, and the effect only shows up when a later lookup misses on the evicted page. The stimulus first fills every slot, then installs new pages and sweeps lookups over all held pages. A long mixed phase draws page numbers from a pool larger than the buffer, so evictions happen at many LFSR phases. A cycle-accurate model tracks the sequence and the slot choice. A directed case also puts a hit and a refill of the same entry in one cycle.

// File: rtl/page_xlat_buf.sv
module page_xlat_buf #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int LFSR_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic                   lk_write,
  input  logic [VA_W-1:0]        lk_vaddr,
  output logic                   hit,
  output logic                   miss,
  output logic [PPN_W+OFF_W-1:0] paddr,
  output logic                   lk_ref,
  output logic                   lk_dirty,
  input  logic                   fill_valid,
  input  logic                   fill_present,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_ref,
  input  logic                   fill_dirty,
  output logic                   page_fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld, refb, dirt, match_vec, fill_match;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [LFSR_W-1:0]  lfsr;
  logic [IDX_W-1:0]   slot;
  logic [PPN_W-1:0]   hit_ppn;
  logic               hit_r, hit_d;

  wire [VPN_W-1:0] lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
  wire             install = fill_valid && fill_present;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g]  = vld[g] && (vpn_q[g] == lk_vpn);
    assign fill_match[g] = vld[g] && (vpn_q[g] == fill_vpn);
  end

  always_comb begin
    hit_ppn = '0;
    hit_r   = 1'b0;
    hit_d   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_r   = hit_r | refb[i];
        hit_d   = hit_d | dirt[i];
      end
    end
  end

  assign hit      = lk_valid && |match_vec;
  assign miss     = lk_valid && !(|match_vec);
  assign paddr    = {hit_ppn, lk_vaddr[OFF_W-1:0]};
  assign lk_ref   = hit && hit_r;
  assign lk_dirty = hit && hit_d;

  always_comb begin
    slot = lfsr[IDX_W-1:0];
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) slot = IDX_W'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) slot = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld        <= '0;
      refb       <= '0;
      dirt       <= '0;
      lfsr       <= LFSR_W'(1);
      page_fault <= 1'b0;
    end else begin
      lfsr       <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_W-2]};
      page_fault <= fill_valid && !fill_present;
      for (int i = 0; i < ENTRIES; i++) begin
        if (lk_valid && match_vec[i]) begin
          refb[i] <= 1'b1;
          if (lk_write) dirt[i] <= 1'b1;
        end
      end
      if (install) begin
        vld[slot]  <= 1'b1;
        refb[slot] <= fill_ref;
        dirt[slot] <= fill_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      vpn_q[slot] <= fill_vpn;
      ppn_q[slot] <= fill_ppn;
    end
  end
endmodule

// File: rtl/page_xlat_buf_chk.sv
module page_xlat_buf_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   lk_valid,
  input logic                   lk_write,
  input logic [VA_W-1:0]        lk_vaddr,
  input logic                   hit,
  input logic [PPN_W+OFF_W-1:0] paddr,
  input logic                   lk_ref,
  input logic                   lk_dirty,
  input logic                   fill_valid,
  input logic                   fill_present,
  input logic [VA_W-OFF_W-1:0]  fill_vpn,
  input logic [PPN_W-1:0]       fill_ppn,
  input logic                   page_fault,
  input logic [ENTRIES-1:0]     match_vec
);
  assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_present |=> page_fault);

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && !fill_present) |=> !page_fault);

  assert_fill_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_present |=>
      (!(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) ||
       (hit && paddr[PPN_W+OFF_W-1:OFF_W] == $past(fill_ppn))));

  assert_ref_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && hit && !fill_valid |=>
      (!(lk_valid && $stable(lk_vaddr)) || (hit && lk_ref)));

  assert_dirty_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_write && hit && !fill_valid |=>
      (!(lk_valid && $stable(lk_vaddr)) || (hit && lk_dirty)));

  assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

bind page_xlat_buf page_xlat_buf_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PPN_W(PPN_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
  .lk_vaddr(lk_vaddr), .hit(hit), .paddr(paddr), .lk_ref(lk_ref),
  .lk_dirty(lk_dirty), .fill_valid(fill_valid), .fill_present(fill_present),
  .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .page_fault(page_fault),
  .match_vec(match_vec)
);

// File: tb/page_xlat_buf_bench.sv
module page_xlat_buf_bench;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk_valid = 0, lk_write = 0, fill_valid = 0, fill_present = 0;
  logic        fill_ref = 0, fill_dirty = 0;
  logic [31:0] lk_vaddr = '0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        hit, miss, lk_ref, lk_dirty, page_fault;
  logic [31:0] paddr;

  page_xlat_buf u_page_xlat_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .hit(hit), .miss(miss), .paddr(paddr),
    .lk_ref(lk_ref), .lk_dirty(lk_dirty), .fill_valid(fill_valid),
    .fill_present(fill_present), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_ref(fill_ref), .fill_dirty(fill_dirty), .page_fault(page_fault)
  );

  logic        m_v [N], m_r [N], m_d [N];
  logic [19:0] m_vpn [N], m_ppn [N];
  logic [3:0]  m_lfsr;
  logic        m_pf;
  int n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit done = 0;

  function automatic int mfind(logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int h, s;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r[i] = 0; m_d[i] = 0; end
      m_lfsr = 4'b0001;
      m_pf = 0;
    end else begin
      h = lk_valid ? mfind(lk_vaddr[31:12]) : -1;
      if (h >= 0) begin m_r[h] = 1; if (lk_write) m_d[h] = 1; end
      m_pf = fill_valid && !fill_present;
      if (fill_valid && fill_present) begin
        s = mfind(fill_vpn);
        if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) s = i;
        if (s < 0) s = int'(m_lfsr[2:0]);
        m_v[s] = 1; m_vpn[s] = fill_vpn; m_ppn[s] = fill_ppn;
        m_r[s] = fill_ref; m_d[s] = fill_dirty;
      end
      m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s (phase %s): actual %h expected %h", req, what, phase, act, exp);
    end
  endtask

  task automatic compare();
    int h;
    logic eh;
    h  = lk_valid ? mfind(lk_vaddr[31:12]) : -1;
    eh = (h >= 0);
    chk("R2", "hit", 32'(hit), 32'(eh));
    chk("R3", "miss", 32'(miss), 32'(lk_valid && !eh));
    if (eh) chk("R2", "paddr", paddr, {m_ppn[h], lk_vaddr[11:0]});
    chk("R4", "lk_ref", 32'(lk_ref), 32'(eh ? m_r[h] : 1'b0));
    chk("R5", "lk_dirty", 32'(lk_dirty), 32'(eh ? m_d[h] : 1'b0));
    chk("R7", "page_fault", 32'(page_fault), 32'(m_pf));
  endtask

  task automatic step(logic lv, logic lw, logic [31:0] va, logic fv, logic fp,
                      logic [19:0] fvp, logic [19:0] fpp, logic fr, logic fd);
    lk_valid = lv; lk_write = lw; lk_vaddr = va;
    fill_valid = fv; fill_present = fp; fill_vpn = fvp; fill_ppn = fpp;
    fill_ref = fr; fill_dirty = fd;
    #2 compare();
    @(negedge clk);
  endtask

  task automatic look(logic [19:0] vpn, logic wr);
    step(1, wr, {vpn, 12'($urandom)}, 0, 0, '0, '0, 0, 0);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic pres, logic r, logic d);
    step(0, 0, '0, 1, pres, vpn, ppn, r, d);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    phase = "R1";
    look(20'h10, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) look(20'h10 + 20'(i), 0);
    step(0, 0, 32'h0001_0abc, 0, 0, '0, '0, 0, 0);

    phase = "R9";
    for (int i = 0; i < N; i++) begin
      fill(20'h10 + 20'(i), 20'hA0000 + 20'(i), 1, 0, 0);
      look(20'h10 + 20'(i), 0);
    end
    look(20'h13, 0);

    phase = "R5";
    look(20'h15, 0);
    look(20'h15, 1);
    look(20'h15, 0);
    look(20'h16, 1);
    look(20'h16, 0);

    phase = "R7";
    fill(20'h30, 20'h12345, 0, 1, 1);
    look(20'h30, 0);
    fill(20'h14, 20'h54321, 0, 0, 0);
    look(20'h14, 0);

    phase = "R8";
    fill(20'h12, 20'hBEEF0, 1, 1, 0);
    look(20'h12, 0);
    for (int i = 0; i < N; i++) look(20'h10 + 20'(i), 0);

    phase = "R6";
    fill(20'h11, 20'h0F0F0, 1, 1, 1);
    look(20'h11, 0);

    phase = "R10";
    for (int k = 0; k < 6; k++) begin
      fill(20'h20 + 20'(k), 20'hC0000 + 20'(k), 1, 0, 0);
      for (int i = 0; i < N; i++) look(20'h10 + 20'(i), 0);
      for (int i = 0; i <= k; i++) look(20'h20 + 20'(i), 0);
    end

    phase = "R11";
    step(1, 1, {20'h20, 12'h123}, 1, 1, 20'h20, 20'h77777, 0, 0);
    look(20'h20, 0);
    step(1, 0, {20'h21, 12'h456}, 1, 1, 20'h21, 20'h66666, 0, 0);
    look(20'h21, 0);

    phase = "mix";
    for (int c = 0; c < 3000; c++) begin
      logic [19:0] v;
      v = 20'h10 + 20'($urandom_range(0, 19));
      if ($urandom_range(0, 3) == 0)
        step($urandom_range(0, 1), $urandom_range(0, 1), {20'h10 + 20'($urandom_range(0, 19)), 12'($urandom)},
             1, ($urandom_range(0, 5) != 0), v, 20'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
      else
        step($urandom_range(0, 4) != 0, $urandom_range(0, 1), {v, 12'($urandom)}, 0, 0, '0, '0, 0, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule